// File: doc/BRIEF.md
# Serial EEPROM Command and Read Front End

This block is the serial slave side of a 512-byte serial EEPROM. It watches an SPI-style link made of a serial clock, an active-low select, a data input and a data output that can be tri-stated. It decodes the instruction byte that opens each transfer and collects the address byte that follows. For array reads it streams bytes out of a byte-wide memory, and the address steps forward after every byte. For status reads it returns the status byte once and then stays silent for the rest of the transfer.

The ninth address bit does not arrive with the address byte. It travels in bit 3 of the read or write instruction and picks the lower or the upper 256-byte page. The block does not time or check non-volatile programming, and it does not apply write protection. It only presents the decoded requests to the logic that does. These requests are latch-enable set and clear, a status-register write, and per-byte array writes.

All serial inputs are sampled in the local `clk` domain. Each serial clock phase must last several `clk` cycles.

Top module: `spi_ee_front`

## Requirements
- R1: An instruction byte whose upper four bits are 0000 is decoded from its low three bits. 110 gives a one-cycle `wrenReq` pulse and 100 gives a one-cycle `wrdiReq` pulse. Bit 3 is ignored for these two codes. Both pulses occur at the 8th rising serial clock edge.
- R2: Instruction 0000A011 followed by address byte D is a read of the 9-bit address {A,D}. Starting at the first falling edge after the 16th rising edge, `miso` presents that byte MSB first and changes one bit per falling edge. `misoEn` is high while the bits are driven.
- R3: If clocking continues, a read outputs the byte at the next address after every 8 bits. The address wraps from 1FFh to 000h.
- R4: Each byte fetched for a read produces exactly one single-cycle `memRd` pulse while `memAddr` holds that byte's address.
- R5: Instruction 0000X101 returns, MSB first over the next 8 falling edges, the `statusIn` value captured at the end of the instruction byte. The value of the status bits does not matter, including a set write-in-progress bit.
- R6: After the 8th status bit has been read (the 16th rising edge), `misoEn` goes low. The data input is then ignored and produces no request until select goes high.
- R7: Instruction 0000X001 followed by exactly 8 data bits, then select rising, gives one `wrsrReq` pulse with `wrsrData` equal to those bits. Any clock after the 8th data bit means no pulse.
- R8: Instruction 0000A010 with address byte D, followed by data bytes, gives one `wrByteValid` pulse per complete data byte. Each pulse carries `wrByteData` and `wrByteAddr`. The address starts at {A,D}, steps by one per byte and wraps at 1FFh.
- R9: Select going high discards any partial instruction and restarts bit counting for the next transfer. It also drops `misoEn` within a few `clk` cycles.
- R10: An instruction whose upper four bits are not 0000, or whose low three bits match none of the six codes, yields no request and no driven output for the rest of the transfer.
- R11: After reset, `misoEn` is low and no request is pulsed.
- R12: After a latch-enable set or clear instruction, further bits in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock (idles low) |
| csN | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in, sampled on rising sclk |
| miso | output | 1 | Serial data out value, changes after falling sclk |
| misoEn | output | 1 | Output enable for miso; low means high impedance |
| memAddr | output | 9 | Array read address |
| memRd | output | 1 | Single-cycle fetch strobe |
| memRdata | input | 8 | Array data at memAddr, combinational |
| statusIn | input | 8 | Current status register contents |
| wrenReq | output | 1 | Set write-enable latch request pulse |
| wrdiReq | output | 1 | Clear write-enable latch request pulse |
| wrsrReq | output | 1 | Status write request pulse |
| wrsrData | output | 8 | Value for the status write |
| wrByteValid | output | 1 | Array byte write request pulse |
| wrByteAddr | output | 9 | Address of the byte write |
| wrByteData | output | 8 | Data of the byte write |

## Verification
A wrong bit count or wrong state shows up within one byte time as a misaligned byte on `miso`, a missing request pulse, or a pulse of the wrong kind. A wrong address counter shows up at the next byte boundary as a bad `memAddr` on a `memRd` pulse, or as a bad `wrByteAddr`, and the page bit and the 1FFh wrap are exercised directly. If the wait state after a status read or an unknown opcode is lost, a stray request or an enabled `miso` appears in the following byte. If a deselect is missed, the next transfer decodes garbage in its first byte.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 9;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [2:0] OPL_WRSR  = 3'b001;
  localparam logic [2:0] OPL_WRITE = 3'b010;
  localparam logic [2:0] OPL_READ  = 3'b011;
  localparam logic [2:0] OPL_WRDI  = 3'b100;
  localparam logic [2:0] OPL_RDSR  = 3'b101;
  localparam logic [2:0] OPL_WREN  = 3'b110;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDATA, ST_SOUT, ST_WDATA, ST_SRIN, ST_SRFULL, ST_WAIT
  } eeState_t;

  typedef struct packed {
    logic shiftIn;
    logic addrLoad;
    logic addrHi;
    logic addrInc;
    logic loadMem;
    logic loadStat;
    logic shiftOut;
    logic outEn;
    logic outDis;
    logic srLoad;
  } dpStrobe_t;
endpackage

// File: rtl/spi_ee_dp.sv
module spi_ee_dp
  import spi_ee_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic [BYTE_W-1:0] statusIn,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              selActive,
  output logic              csRise,
  output logic [BYTE_W-1:0] inByte,
  output logic [ADDR_W-1:0] addr,
  output logic              miso,
  output logic              misoEn,
  output logic [BYTE_W-1:0] srData
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0]        pipe [SYNC_STAGES];
  logic              prevSclk, prevCs;
  logic [BYTE_W-1:0] inShift, outShift, srQ;
  logic [ADDR_W-1:0] addrQ;
  logic              misoQ, misoEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b010;
      prevSclk <= 1'b0;
      prevCs   <= 1'b1;
    end else begin
      pipe[0] <= {sclk, csN, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      prevSclk <= pipe[LAST][2];
      prevCs   <= pipe[LAST][1];
    end
  end

  assign sclkRise  = pipe[LAST][2] & ~prevSclk;
  assign sclkFall  = ~pipe[LAST][2] & prevSclk;
  assign selActive = ~pipe[LAST][1];
  assign csRise    = pipe[LAST][1] & ~prevCs;
  assign inByte    = {inShift[BYTE_W-2:0], pipe[LAST][0]};

  // input shifter and status-write capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
      srQ     <= '0;
    end else begin
      if (strobe.shiftIn) inShift <= inByte;
      if (strobe.srLoad)  srQ     <= inByte;
    end
  end

  // address counter, 9 bits, natural wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.addrLoad) begin
      addrQ <= {strobe.addrHi, inByte};
    end else if (strobe.addrInc) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  // output shifter and enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      misoQ    <= 1'b0;
      misoEnQ  <= 1'b0;
    end else begin
      if (strobe.loadMem) begin
        outShift <= memRdata;
      end else if (strobe.loadStat) begin
        outShift <= statusIn;
      end else if (strobe.shiftOut) begin
        outShift <= {outShift[BYTE_W-2:0], 1'b0};
      end
      if (strobe.shiftOut) misoQ <= outShift[BYTE_W-1];
      if (strobe.outDis) begin
        misoEnQ <= 1'b0;
        misoQ   <= 1'b0;
      end else if (strobe.outEn) begin
        misoEnQ <= 1'b1;
      end
    end
  end

  assign addr   = addrQ;
  assign miso   = misoQ;
  assign misoEn = misoEnQ;
  assign srData = srQ;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addrInc && !strobe.addrLoad) |=> addrQ == ADDR_W'($past(addrQ) + 1'b1)); // R3

  AST_EN_ON_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoEnQ) |-> $past(strobe.shiftOut)); // R2
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              selActive,
  input  logic              csRise,
  input  logic [BYTE_W-1:0] inByte,
  output dpStrobe_t         strobe,
  output logic              wrenReq,
  output logic              wrdiReq,
  output logic              wrsrReq,
  output logic              wrByteValid
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eeState_t         state, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN, outCnt, outCntN;
  logic             needLoad, needLoadN, isRead, isReadN, pageHi, pageHiN;
  logic             byteDone, opValid;

  assign byteDone = sclkRise && (bitCnt == LAST_BIT);
  assign opValid  = (inByte[BYTE_W-1:4] == '0);

  always_comb begin
    strobe      = '0;
    wrenReq     = 1'b0;
    wrdiReq     = 1'b0;
    wrsrReq     = 1'b0;
    wrByteValid = 1'b0;
    stateN      = state;
    bitCntN     = bitCnt;
    outCntN     = outCnt;
    needLoadN   = needLoad;
    isReadN     = isRead;
    pageHiN     = pageHi;
    if (!selActive) begin
      stateN        = ST_CMD;
      bitCntN       = '0;
      outCntN       = '0;
      needLoadN     = 1'b0;
      strobe.outDis = 1'b1;
      if (csRise && state == ST_SRFULL) wrsrReq = 1'b1;
    end else begin
      if (sclkRise) bitCntN = bitCnt + 1'b1;
      unique case (state)
        ST_CMD: begin
          strobe.shiftIn = sclkRise;
          if (byteDone) begin
            stateN = ST_WAIT;
            if (opValid) begin
              case (inByte[2:0])
                OPL_WREN: wrenReq = 1'b1;
                OPL_WRDI: wrdiReq = 1'b1;
                OPL_RDSR: begin
                  strobe.loadStat = 1'b1;
                  stateN          = ST_SOUT;
                end
                OPL_WRSR: stateN = ST_SRIN;
                OPL_READ, OPL_WRITE: begin
                  isReadN = inByte[0];
                  pageHiN = inByte[3];
                  stateN  = ST_ADDR;
                end
                default: stateN = ST_WAIT;
              endcase
            end
          end
        end
        ST_ADDR: begin
          strobe.shiftIn = sclkRise;
          if (byteDone) begin
            strobe.addrLoad = 1'b1;
            strobe.addrHi   = pageHi;
            stateN          = isRead ? ST_RDATA : ST_WDATA;
            needLoadN       = isRead;
          end
        end
        ST_RDATA: begin
          if (needLoad) begin
            strobe.loadMem = 1'b1;
            needLoadN      = 1'b0;
          end
          if (sclkFall) begin
            strobe.shiftOut = 1'b1;
            strobe.outEn    = 1'b1;
            outCntN         = outCnt + 1'b1;
            if (outCnt == LAST_BIT) begin
              strobe.addrInc = 1'b1;
              needLoadN      = 1'b1;
            end
          end
        end
        ST_SOUT: begin
          if (sclkFall) begin
            strobe.shiftOut = 1'b1;
            strobe.outEn    = 1'b1;
          end
          if (byteDone) begin
            strobe.outDis = 1'b1;
            stateN        = ST_WAIT;
          end
        end
        ST_WDATA: begin
          strobe.shiftIn = sclkRise;
          if (byteDone) begin
            wrByteValid    = 1'b1;
            strobe.addrInc = 1'b1;
          end
        end
        ST_SRIN: begin
          strobe.shiftIn = sclkRise;
          if (byteDone) begin
            strobe.srLoad = 1'b1;
            stateN        = ST_SRFULL;
          end
        end
        ST_SRFULL: if (sclkRise) stateN = ST_WAIT;
        ST_WAIT: ;
        default: stateN = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      outCnt   <= '0;
      needLoad <= 1'b0;
      isRead   <= 1'b0;
      pageHi   <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      outCnt   <= outCntN;
      needLoad <= needLoadN;
      isRead   <= isReadN;
      pageHi   <= pageHiN;
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrenReq, wrdiReq, wrsrReq, wrByteValid})); // R1

  AST_WAIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && selActive) |=> (state == ST_WAIT || !selActive)); // R6

  AST_DESEL_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> (state == ST_CMD && bitCnt == '0)); // R9

  AST_WRSR_ON_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    wrsrReq |-> $past(selActive)); // R7
endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front
  import spi_ee_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              misoEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic [BYTE_W-1:0] statusIn,
  output logic              wrenReq,
  output logic              wrdiReq,
  output logic              wrsrReq,
  output logic [BYTE_W-1:0] wrsrData,
  output logic              wrByteValid,
  output logic [ADDR_W-1:0] wrByteAddr,
  output logic [BYTE_W-1:0] wrByteData
);
  dpStrobe_t         strobe;
  logic              sclkRise, sclkFall, selActive, csRise;
  logic [BYTE_W-1:0] inByte;
  logic [ADDR_W-1:0] addr;

  spi_ee_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .selActive(selActive), .csRise(csRise), .inByte(inByte), .strobe(strobe),
    .wrenReq(wrenReq), .wrdiReq(wrdiReq), .wrsrReq(wrsrReq),
    .wrByteValid(wrByteValid)
  );

  spi_ee_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .strobe(strobe), .memRdata(memRdata), .statusIn(statusIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .selActive(selActive),
    .csRise(csRise), .inByte(inByte), .addr(addr), .miso(miso),
    .misoEn(misoEn), .srData(wrsrData)
  );

  assign memAddr    = addr;
  assign memRd      = strobe.loadMem;
  assign wrByteAddr = addr;
  assign wrByteData = inByte;

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> !misoEn); // R9

  AST_FETCH_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, wrByteValid, wrsrReq})); // R4
endmodule

// File: tb/spi_ee_front_tb_top.sv
module spi_ee_front_tb_top;
  localparam int HALF = 4;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] addr;
    logic [7:0] seed;
    logic [3:0] n;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'h06, 8'h00, 8'h40, 4'd2},  // R1 R12 set enable, extra bytes
    '{8'h0E, 8'h00, 8'h40, 4'd0},  // R1 bit3 don't care
    '{8'h04, 8'h00, 8'h40, 4'd1},  // R1 R12 clear enable
    '{8'h05, 8'h00, 8'h04, 4'd2},  // R5 R6 status, then 06h ignored
    '{8'h01, 8'h5A, 8'h00, 4'd1},  // R7 status write
    '{8'h01, 8'h5A, 8'h00, 4'd2},  // R7 too many clocks
    '{8'h0B, 8'hFE, 8'h00, 4'd4},  // R2 R3 R4 upper page wrap
    '{8'h03, 8'hFE, 8'h00, 4'd3},  // R2 lower page
    '{8'h02, 8'h20, 8'h70, 4'd3},  // R8 write
    '{8'h0A, 8'hFF, 8'h90, 4'd3},  // R8 write wrap
    '{8'h07, 8'h00, 8'h40, 4'd2},  // R10 unknown code
    '{8'h46, 8'h00, 8'h40, 4'd1},  // R10 upper nibble set
    '{8'h83, 8'h10, 8'h40, 4'd3}   // R10 read-like, invalid
  };

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, misoEn, memRd, wrenReq, wrdiReq, wrsrReq, wrByteValid;
  logic [8:0] memAddr, wrByteAddr;
  logic [7:0] memRdata, statusIn = 8'h8D, wrsrData, wrByteData;

  int nChecks = 0, nFails = 0;
  int wrenCnt = 0, wrdiCnt = 0, wrsrCnt = 0, wbCnt = 0, rdCnt = 0;
  logic [7:0] lastWrsr;
  logic [8:0] wbAddr [16];
  logic [7:0] wbData [16];
  logic [8:0] rdAddr [16];
  logic [7:0] rxSlot [16];
  logic       enSlot [16];
  logic       enEver;

  always #4 clk = ~clk;

  function automatic logic [7:0] memFn(input logic [8:0] a);
    return a[7:0] * 8'd29 + 8'h11 + (a[8] ? 8'h80 : 8'h00);
  endfunction

  assign memRdata = memFn(memAddr);

  spi_ee_front dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .misoEn(misoEn), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .statusIn(statusIn), .wrenReq(wrenReq),
    .wrdiReq(wrdiReq), .wrsrReq(wrsrReq), .wrsrData(wrsrData),
    .wrByteValid(wrByteValid), .wrByteAddr(wrByteAddr), .wrByteData(wrByteData)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (wrenReq) wrenCnt <= wrenCnt + 1;
      if (wrdiReq) wrdiCnt <= wrdiCnt + 1;
      if (wrsrReq) begin
        wrsrCnt  <= wrsrCnt + 1;
        lastWrsr <= wrsrData;
      end
      if (wrByteValid && wbCnt < 16) begin
        wbAddr[wbCnt] <= wrByteAddr;
        wbData[wbCnt] <= wrByteData;
        wbCnt <= wbCnt + 1;
      end
      if (memRd && rdCnt < 16) begin
        rdAddr[rdCnt] <= memAddr;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic waitHalf;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startTxn;
    @(negedge clk);
    csN = 1'b0;
    sclk = 1'b0;
    enEver = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rxSlot[i] = 8'h00;
      enSlot[i] = 1'b0;
    end
    waitHalf();
  endtask

  task automatic clockBit(input logic b, input int slot);
    mosi = b;
    waitHalf();
    rxSlot[slot] = {rxSlot[slot][6:0], miso};
    enSlot[slot] = enSlot[slot] | misoEn;
    enEver = enEver | misoEn;
    sclk = 1'b1;
    waitHalf();
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input int slot);
    for (int i = 7; i >= 0; i--) clockBit(v[i], slot);
  endtask

  task automatic endTxn;
    mosi = 1'b0;
    waitHalf();
    csN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check(misoEn == 1'b0, "R11", "misoEn in reset", misoEn, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(misoEn == 1'b0, "R11", "misoEn after reset", misoEn, 0);
    check(wrenCnt + wrdiCnt + wrsrCnt + wbCnt + rdCnt == 0, "R11", "pulses after reset",
          wrenCnt + wrdiCnt + wrsrCnt + wbCnt + rdCnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      vec_t e;
      int w0, d0, s0, b0, r0, n;
      logic valid;
      logic [2:0] low;
      logic [8:0] a9;
      e = VECS[v];
      n = int'(e.n);
      valid = (e.op[7:4] == 4'h0);
      low = e.op[2:0];
      a9 = {e.op[3], e.addr};
      w0 = wrenCnt; d0 = wrdiCnt; s0 = wrsrCnt; b0 = wbCnt; r0 = rdCnt;
      startTxn();
      for (int s = 0; s <= n; s++)
        sendByte((s == 0) ? e.op : (s == 1) ? e.addr : 8'(e.seed + 8'(s)), s);
      endTxn();

      check(wrenCnt - w0 == ((valid && low == 3'b110) ? 1 : 0), "R1", "set-enable pulses",
            wrenCnt - w0, (valid && low == 3'b110) ? 1 : 0);
      check(wrdiCnt - d0 == ((valid && low == 3'b100) ? 1 : 0), "R12", "clear-enable pulses",
            wrdiCnt - d0, (valid && low == 3'b100) ? 1 : 0);
      check(wrsrCnt - s0 == ((valid && low == 3'b001 && n == 1) ? 1 : 0), "R7",
            "status write pulses", wrsrCnt - s0, (valid && low == 3'b001 && n == 1) ? 1 : 0);
      if (valid && low == 3'b001 && n == 1)
        check(lastWrsr == e.addr, "R7", "status write data", lastWrsr, e.addr);
      check(wbCnt - b0 == ((valid && low == 3'b010 && n >= 2) ? n - 1 : 0), "R8",
            "byte write pulses", wbCnt - b0, (valid && low == 3'b010 && n >= 2) ? n - 1 : 0);
      check(rdCnt - r0 == ((valid && low == 3'b011) ? n : 0), "R4", "fetch pulses",
            rdCnt - r0, (valid && low == 3'b011) ? n : 0);

      if (valid && low == 3'b011) begin
        for (int k = 0; k < n; k++) begin
          logic [8:0] ea;
          ea = a9 + 9'(k);
          check(rdAddr[r0 + k] == ea, "R4", "fetch address", rdAddr[r0 + k], ea);
        end
        for (int s = 2; s <= n; s++) begin
          logic [8:0] ea;
          ea = a9 + 9'(s - 2);
          check(rxSlot[s] == memFn(ea), (s == 2) ? "R2" : "R3", "read byte",
                rxSlot[s], memFn(ea));
          check(enSlot[s] == 1'b1, "R2", "misoEn while reading", enSlot[s], 1);
        end
      end else if (valid && low == 3'b101) begin
        check(rxSlot[1] == statusIn, "R5", "status byte", rxSlot[1], statusIn);
        check(enSlot[2] == 1'b0, "R6", "misoEn after status", enSlot[2], 0);
      end else if (valid && low == 3'b010) begin
        for (int k = 0; k < n - 1; k++) begin
          logic [8:0] ea;
          logic [7:0] ed;
          ea = a9 + 9'(k);
          ed = 8'(e.seed + 8'(k + 2));
          check(wbAddr[b0 + k] == ea, "R8", "write address", wbAddr[b0 + k], ea);
          check(wbData[b0 + k] == ed, "R8", "write data", wbData[b0 + k], ed);
        end
      end else begin
        check(enEver == 1'b0, valid ? "R12" : "R10", "misoEn never raised", enEver, 0);
      end
    end

    // R10 unknown low code with no further pulses of any kind
    begin
      int tot0;
      tot0 = wrenCnt + wrdiCnt + wrsrCnt + wbCnt + rdCnt;
      startTxn();
      sendByte(8'h00, 0);
      sendByte(8'h06, 1);
      sendByte(8'h03, 2);
      endTxn();
      check(wrenCnt + wrdiCnt + wrsrCnt + wbCnt + rdCnt == tot0, "R10", "opcode 00h ignored",
            wrenCnt + wrdiCnt + wrsrCnt + wbCnt + rdCnt, tot0);
    end

    // R9 partial instruction aborted by deselect
    begin
      int w0;
      w0 = wrenCnt;
      startTxn();
      for (int i = 0; i < 6; i++) clockBit((i == 5) ? 1'b1 : 1'b0, 0);
      endTxn();
      statusIn = 8'h03;
      startTxn();
      sendByte(8'h05, 0);
      sendByte(8'h00, 1);
      endTxn();
      check(rxSlot[1] == 8'h03, "R9", "status after aborted bits", rxSlot[1], 8'h03);
      check(wrenCnt == w0, "R9", "no pulse from partial bits", wrenCnt, w0);
      // R5 status with write-in-progress set returned unchanged
      check(rxSlot[1][0] == 1'b1, "R5", "busy bit readable", rxSlot[1][0], 1);
    end

    // R9 deselect in the middle of a read drops the output enable
    startTxn();
    sendByte(8'h03, 0);
    sendByte(8'h40, 1);
    for (int i = 0; i < 3; i++) clockBit(1'b0, 2);
    check(misoEn == 1'b1, "R2", "misoEn during read", misoEn, 1);
    endTxn();
    check(misoEn == 1'b0, "R9", "misoEn after deselect", misoEn, 0);

    // R7 a 17th clock cancels the status write; short data also cancels
    begin
      int s0;
      s0 = wrsrCnt;
      startTxn();
      sendByte(8'h01, 0);
      sendByte(8'h3C, 1);
      clockBit(1'b0, 2);
      endTxn();
      check(wrsrCnt == s0, "R7", "17 clocks no status write", wrsrCnt, s0);
      startTxn();
      sendByte(8'h09, 0);
      for (int i = 0; i < 4; i++) clockBit(1'b1, 1);
      endTxn();
      check(wrsrCnt == s0, "R7", "12 clocks no status write", wrsrCnt, s0);
      startTxn();
      sendByte(8'h09, 0);
      sendByte(8'hC3, 1);
      endTxn();
      check(wrsrCnt == s0 + 1, "R7", "bit3 set status write", wrsrCnt, s0 + 1);
      check(lastWrsr == 8'hC3, "R7", "status write value", lastWrsr, 8'hC3);
    end

    finishRun();
  end
endmodule